// File: doc/BRIEF.md
# Gated Six-Way Clock Fanout

This block takes two clock sources, a fast system clock and a slower scan/test clock, picks one of them with a select pin, and copies the chosen clock to six outputs. Each output can be switched on or off by itself. A shared enable can also switch all six off at once. Every enable is active low.

The enable pins are not applied directly. They go into flip-flops that capture on the falling edge of the selected clock. An output therefore changes between gated and running only while the clock is already low. When an output is switched off, its last high pulse keeps its full width. When it is switched back on, its first pulse is also full width. A disabled output rests low.

The enable registers start in an unknown state on a real power-up. A synchronous active-low reset, also sampled on the falling edge of the selected clock, clears every enable to the off state so that start-up is known. Changing the source select is a configuration step, done while the block is held in reset. The block does not promise a clean switch between sources while it is running.

Top module: `clk_fanout_gated`

## Requirements
- R1: With `scan_sel` low, every enabled output follows `clk_sys`. With `scan_sel` high, every enabled output follows `clk_scan`, so its high pulses last one `clk_scan` high phase.
- R2: Output k is enabled when both `all_en_n` and `out_en_n[k]` were low at the most recent falling edge of the selected clock. Bit k of `out_en_n` controls bit k of `clk_out`.
- R3: `all_en_n` high at a falling edge disables all six outputs, whatever `out_en_n` holds.
- R4: An enable change made while the selected clock is high has no effect on the outputs during that high phase. It takes effect from the next falling edge.
- R5: A disabled output is held low, and every output is low while the selected clock is low.
- R6: Disabling an output during a high phase does not shorten that pulse. Enabling it during a high phase produces no partial pulse. Every output high pulse lasts exactly one high phase of the selected clock.
- R7: `rst_n` low at a falling edge of the selected clock clears all enables, so every output stays low until enables are captured after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Primary system clock source |
| clk_scan | input | 1 | Slower scan/test clock source |
| scan_sel | input | 1 | 0 selects `clk_sys`, 1 selects `clk_scan` |
| rst_n | input | 1 | Synchronous active-low reset, sampled on the falling edge of the selected clock |
| all_en_n | input | 1 | Common active-low enable shared by all outputs |
| out_en_n | input | 6 | Per-output active-low enables, bit k for output k |
| clk_out | output | 6 | Gated copies of the selected clock |

## Verification
The only register stage is the enable capture on the falling edge. A stimulus applied during a high phase is therefore due at the outputs in the next high phase of the selected clock, not in the current one.

For every vector the bench drives the enables 1 ns into a high phase. It then samples the outputs three times, each well away from a clock edge:
- 0.5 ns later, in the same high phase, expecting the old state;
- 1 ns into the following low phase, expecting all zeros;
- 1 ns into the next high phase, expecting the new state.

Pulse-width checks time whole output pulses against the selected clock's half period. Enables are changed in the middle of a high phase for these checks, which is where a shortened or partial pulse would show.

// File: rtl/clk_fanout_pkg.sv
// Package: shared constants and types for the gated clock fanout.
// Assumes: nothing; holds no logic.
package clk_fanout_pkg;
    localparam int unsigned DEFAULT_OUTS = 6;

    // Source choice encoded on the select pin.
    typedef enum logic {
        SRC_SYS  = 1'b0,
        SRC_SCAN = 1'b1
    } clk_src_e;
endpackage

// File: rtl/clk_src_mux.sv
// Module: picks one of two clock sources from a static select.
// Assumes: sel changes only while downstream enables are cleared.
module clk_src_mux
    import clk_fanout_pkg::*;
(
    input  logic clk_a,
    input  logic clk_b,
    input  logic sel,
    output logic clk_y
);
    clk_src_e src;

    // Decode the select pin into a named source.
    always_comb begin
        src = clk_src_e'(sel);
    end

    // Route the chosen source to the output.
    always_comb begin
        if (src == SRC_SCAN) begin
            clk_y = clk_b;
        end else begin
            clk_y = clk_a;
        end
    end
endmodule

// File: rtl/gate_en_reg.sv
// Module: captures per-output enables on the falling clock edge.
// An output is enabled when the common and individual active-low enables are both low.
// Assumes: the clock given here is the selected clock; rst_n is synchronous, active low.
module gate_en_reg #(
    parameter int unsigned NUM_OUT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               all_en_n,
    input  logic [NUM_OUT-1:0] out_en_n,
    output logic [NUM_OUT-1:0] en_q
);
    logic [NUM_OUT-1:0] en_d;

    // Combine the shared and individual requests per output.
    always_comb begin
        en_d = '0;
        for (int k = 0; k < NUM_OUT; k++) begin
            en_d[k] = ~(all_en_n | out_en_n[k]);
        end
    end

    // Capture enables while the clock is falling into its low phase.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end
endmodule

// File: rtl/clk_and_gate.sv
// Module: one AND gate per output, combining the clock with its registered enable.
// Assumes: each enable changes only while clk is low, so no partial pulse can form.
module clk_and_gate #(
    parameter int unsigned NUM_OUT = 6
) (
    input  logic               clk,
    input  logic [NUM_OUT-1:0] en_q,
    output logic [NUM_OUT-1:0] clk_out
);
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_gate
        // Pass the clock through only when this output is enabled.
        always_comb begin
            clk_out[g] = clk & en_q[g];
        end
    end
endmodule

// File: rtl/clk_fanout_gated.sv
// Module (top): selects a clock source and fans it out to NUM_OUT outputs.
// Each output has a gate that switches only in the clock's low phase.
// Assumes: scan_sel is changed only while rst_n is held low.
module clk_fanout_gated #(
    parameter int unsigned NUM_OUT = clk_fanout_pkg::DEFAULT_OUTS
) (
    input  logic               clk_sys,
    input  logic               clk_scan,
    input  logic               scan_sel,
    input  logic               rst_n,
    input  logic               all_en_n,
    input  logic [NUM_OUT-1:0] out_en_n,
    output logic [NUM_OUT-1:0] clk_out
);
    logic               sel_clk;
    logic [NUM_OUT-1:0] en_q;

    clk_src_mux u_mux (
        .clk_a (clk_sys),
        .clk_b (clk_scan),
        .sel   (scan_sel),
        .clk_y (sel_clk)
    );

    gate_en_reg #(.NUM_OUT(NUM_OUT)) u_en (
        .clk      (sel_clk),
        .rst_n    (rst_n),
        .all_en_n (all_en_n),
        .out_en_n (out_en_n),
        .en_q     (en_q)
    );

    clk_and_gate #(.NUM_OUT(NUM_OUT)) u_gate (
        .clk     (sel_clk),
        .en_q    (en_q),
        .clk_out (clk_out)
    );
endmodule

// File: rtl/clk_fanout_chk.sv
// Module: assertion checker for clk_fanout_gated, attached with bind.
// Sampled on the falling edge of the selected clock, where the enables move.
module clk_fanout_chk #(
    parameter int unsigned NUM_OUT = 6
) (
    input logic               sel_clk,
    input logic               rst_n,
    input logic               all_en_n,
    input logic [NUM_OUT-1:0] out_en_n,
    input logic [NUM_OUT-1:0] en_q,
    input logic [NUM_OUT-1:0] clk_out
);
    // R7: reset seen at a falling edge leaves every enable cleared.
    assert_reset_clears_R7: assert property (@(negedge sel_clk)
        !rst_n |=> (en_q == '0));

    // R3: common disable turns every output off.
    assert_common_off_R3: assert property (@(negedge sel_clk) disable iff (!rst_n)
        all_en_n |=> (en_q == '0));

    // R5: just before the fall (clock still high), each output equals its enable.
    assert_out_tracks_en_R5: assert property (@(negedge sel_clk) disable iff (!rst_n)
        clk_out == en_q);

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_bit
        // R2: both enables low turn output g on.
        assert_bit_on_R2: assert property (@(negedge sel_clk) disable iff (!rst_n)
            (!all_en_n && !out_en_n[g]) |=> en_q[g]);
        // R2: individual enable high turns output g off.
        assert_bit_off_R2: assert property (@(negedge sel_clk) disable iff (!rst_n)
            out_en_n[g] |=> !en_q[g]);
    end
endmodule

bind clk_fanout_gated clk_fanout_chk #(.NUM_OUT(NUM_OUT)) u_chk (
    .sel_clk  (sel_clk),
    .rst_n    (rst_n),
    .all_en_n (all_en_n),
    .out_en_n (out_en_n),
    .en_q     (en_q),
    .clk_out  (clk_out)
);

// File: tb/clk_fanout_gated_test.sv
`timescale 1ns/1ps
module clk_fanout_gated_test;
    localparam int N = 6;
    localparam real SYS_HALF  = 2.5;
    localparam real SCAN_HALF = 10.0;
    // Vector: [12] all_en_n, [11:6] out_en_n, [5:0] expected outputs during the next high phase.
    localparam int NV = 9;
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 6'b000000, 6'b111111},
        {1'b0, 6'b101010, 6'b010101},
        {1'b0, 6'b010101, 6'b101010},
        {1'b1, 6'b000000, 6'b000000},
        {1'b1, 6'b111000, 6'b000000},
        {1'b0, 6'b111000, 6'b000111},
        {1'b0, 6'b111111, 6'b000000},
        {1'b0, 6'b011110, 6'b100001},
        {1'b0, 6'b000000, 6'b111111}
    };

    logic clk_sys = 1'b0, clk_scan = 1'b0, scan_sel = 1'b0, rst_n = 1'b0;
    logic all_en_n = 1'b1;
    logic [N-1:0] out_en_n = '1;
    logic [N-1:0] clk_out;
    logic [N-1:0] cur_exp = '0;
    int n_chk = 0, n_bad = 0;

    always #(SYS_HALF)  clk_sys  = ~clk_sys;
    always #(SCAN_HALF) clk_scan = ~clk_scan;

    clk_fanout_gated #(.NUM_OUT(N)) uut (
        .clk_sys(clk_sys), .clk_scan(clk_scan), .scan_sel(scan_sel), .rst_n(rst_n),
        .all_en_n(all_en_n), .out_en_n(out_en_n), .clk_out(clk_out)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: clk_out=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_w(input string req, input real act, input real exp);
        n_chk++;
        if (act < exp - 0.01 || act > exp + 0.01) begin
            n_bad++;
            $display("FAIL %s: pulse width %0.3f expected %0.3f", req, act, exp);
        end
    endtask

    task automatic wait_rise();
        if (scan_sel) @(posedge clk_scan); else @(posedge clk_sys);
    endtask

    task automatic wait_fall();
        if (scan_sel) @(negedge clk_scan); else @(negedge clk_sys);
    endtask

    // Drive mid-high, then check: same high phase (old), low phase (zero), next high (new).
    task automatic apply(input logic c, input logic [N-1:0] ind, input logic [N-1:0] exp, input string req);
        wait_rise();
        #1;
        all_en_n = c;
        out_en_n = ind;
        #0.5;
        chk("R4 no change mid-high", clk_out, cur_exp);
        wait_fall();
        #1;
        chk("R5 low phase", clk_out, '0);
        wait_rise();
        #1;
        chk(req, clk_out, exp);
        cur_exp = exp;
    endtask

    initial begin
        real t0;
        // R7: reset held with all enables requested keeps outputs low.
        all_en_n = 1'b0;
        out_en_n = '0;
        repeat (3) wait_rise();
        #1;
        chk("R7 reset holds outputs low", clk_out, '0);
        wait_rise();
        #1;
        rst_n = 1'b1;
        #0.5;
        chk("R7 release mid-high", clk_out, '0);
        wait_rise();
        #1;
        chk("R7 enabled after release", clk_out, '1);
        cur_exp = '1;

        // R2 / R3 / R4 / R5: table walk on the system clock.
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][12], VEC[i][11:6], VEC[i][5:0],
                  VEC[i][12] ? "R3 common disable" : "R2 per-output enable");
        end

        // R6: disabling mid-pulse leaves the pulse at full width.
        wait_rise();
        t0 = $realtime;
        #1;
        all_en_n = 1'b1;
        @(negedge clk_out[2]);
        chk_w("R6 disable keeps full pulse", $realtime - t0, SYS_HALF);
        wait_rise();
        #1;
        chk("R6 disabled stays low", clk_out, '0);

        // R6: enabling mid-high gives no partial pulse; first pulse is full.
        all_en_n = 1'b0;
        out_en_n = 6'b111011;
        #0.5;
        chk("R6 no partial pulse", clk_out, '0);
        @(posedge clk_out[2]);
        t0 = $realtime;
        @(negedge clk_out[2]);
        chk_w("R6 first pulse full width", $realtime - t0, SYS_HALF);

        // R1: switch to the scan clock while held in reset.
        wait_rise();
        #1;
        rst_n = 1'b0;
        wait_fall();
        #1;
        scan_sel = 1'b1;
        out_en_n = '0;
        repeat (2) wait_rise();
        #1;
        chk("R7 reset in scan mode", clk_out, '0);
        rst_n = 1'b1;
        wait_rise();
        #1;
        chk("R1 scan clock enabled", clk_out, '1);
        cur_exp = '1;
        @(posedge clk_out[2]);
        t0 = $realtime;
        @(negedge clk_out[2]);
        chk_w("R1 follows scan clock", $realtime - t0, SCAN_HALF);
        apply(1'b0, 6'b001100, 6'b110011, "R1 scan clock per-output");

        // R6 in scan mode: disable mid-pulse.
        wait_rise();
        t0 = $realtime;
        #1;
        out_en_n = '1;
        @(negedge clk_out[0]);
        chk_w("R6 scan disable full pulse", $realtime - t0, SCAN_HALF);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000.0);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule